// File: doc/BRIEF.md
# Current Fault Blanking and Latch

This block guards the three switch drives of a battery pack (charge, discharge and precharge) against excess current without waiting for a host. Analog comparators outside the block raise four flags, already synchronous to the system clock. The flags are charge overcurrent, discharge overload, charge short circuit and discharge short circuit. Each flag must persist for its own programmable blanking time before it counts as a fault. A fault that outlasts its blanking time turns the charge and discharge drives off and turns the precharge drive on. It is held in a fault latch until the host releases it.

The host sets the drives through enable bits. An active-low enable pin and a shutdown flag override the host bits. Blanking time is counted in ticks of a 32.768 kHz timebase. That timebase comes from an external slow clock while the clock keeps toggling. Once the external clock has been silent for a set number of system clocks, the timebase comes from an internal divider of the system clock. Delays are measured in ticks: 1 ms is 33 ticks and one short-circuit step is 2 ticks.

Top module: `pack_fault_guard`

## Requirements
- R1: The charge-overcurrent and discharge-overload blanking times are OC_BASE + OC_STEP × code ticks (33 + 66 × code by default), each set by its own 4-bit code.
- R2: Each short-circuit blanking time is SC_STEP × code ticks (2 × code by default), set separately for each direction. Code 0 latches on the first clock edge that samples the flag.
- R3: A flag that drops before its blanking time runs out resets its timer to zero and latches nothing, so a later pulse starts counting again from zero.
- R4: When a fault latches, the charge and discharge drives go low and the precharge drive goes high on the following cycle. The matching faultFlags bit is set: bit 0 discharge short, bit 1 charge short, bit 2 discharge overload, bit 3 charge overcurrent. faultLatched is the OR of those bits.
- R5: The latch clears only on a falling edge of hostRelease that follows a rising edge seen while latched. Holding hostRelease high keeps the latch set. A fault still present after the release latches again.
- R6: chgDrive equals hostChgEn and dsgDrive equals hostDsgEn only while the latch is clear, enPinN is low and shutdown is low. Otherwise both drives are low.
- R7: With enPinN low and shutdown low, pchgDrive is high when hostPchgOff is 0 or the latch is set, and low only when hostPchgOff is 1 with the latch clear.
- R8: enPinN high or shutdown high forces all three drives low.
- R9: While hostChgEn and hostDsgEn are both 0, no flag can set the latch.
- R10: Rising edges on extClk hold the internal divider off and serve as ticks, and timebaseExt is high. After EXT_TIMEOUT system clocks with no extClk edge, timebaseExt drops and the internal divider (one tick per INT_DIV clocks) takes over.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| extClk | input | 1 | External slow clock (asynchronous, synchronised inside) |
| fltChgOc | input | 1 | Charge overcurrent comparator flag |
| fltDsgOl | input | 1 | Discharge overload comparator flag |
| fltChgSc | input | 1 | Charge short-circuit comparator flag |
| fltDsgSc | input | 1 | Discharge short-circuit comparator flag |
| chgOcCode | input | CODE_W | Charge overcurrent blanking code |
| dsgOlCode | input | CODE_W | Discharge overload blanking code |
| chgScCode | input | CODE_W | Charge short-circuit blanking code |
| dsgScCode | input | CODE_W | Discharge short-circuit blanking code |
| hostChgEn | input | 1 | Host request for the charge drive |
| hostDsgEn | input | 1 | Host request for the discharge drive |
| hostPchgOff | input | 1 | Host request to turn the precharge drive off |
| hostRelease | input | 1 | Latch release bit (0-1-0 sequence) |
| enPinN | input | 1 | Active-low drive enable pin |
| shutdown | input | 1 | Shutdown condition, forces drives off |
| chgDrive | output | 1 | Charge switch drive |
| dsgDrive | output | 1 | Discharge switch drive |
| pchgDrive | output | 1 | Precharge switch drive |
| faultLatched | output | 1 | Fault latch state |
| faultFlags | output | 4 | Latched fault causes |
| timebaseExt | output | 1 | High while the external clock supplies ticks |

## Verification
Random combinations of the host bits, the enable pin and shutdown, with no faults present, are compared against a model of the drive gating. This separates the gating order of latch, pin and shutdown from the plain host-bit paths. Flags are then held on until the latch sets, with random direction and code. The measured trip time is checked against a window of one tick around the formula, which shows whether the right limit formula is wired to each direction and that code 0 trips at once. Short pulses below the limit, a release held high, a release with the fault still present, and flags with both host enables off each separate one latch or timer rule from its neighbours. Trip times taken with and without a toggling extClk show which timebase is in use.

// File: rtl/fault_guard_pkg.sv
package fault_guard_pkg;

  // Fault index order inside the packed flag vector; faultFlags uses the same order.
  localparam int FIDX_DSG_SC = 0;
  localparam int FIDX_CHG_SC = 1;
  localparam int FIDX_DSG_OL = 2;
  localparam int FIDX_CHG_OC = 3;
  localparam int NUM_FAULTS  = 4;

  // Strobes sent from the control module to the timer datapath.
  typedef struct packed {
    logic detectEn;   // timers may run
    logic clearAll;   // latch released this cycle, restart timers
  } ctrlStrobe_t;

endpackage

// File: rtl/fg_timebase.sv
module fg_timebase #(
  parameter int INT_DIV     = 1526,
  parameter int EXT_TIMEOUT = 4096
) (
  input  logic clk,
  input  logic rstN,
  input  logic extClk,
  output logic tick,
  output logic extActive
);
  localparam int SIL_W = $clog2(EXT_TIMEOUT + 1);
  localparam int DIV_W = (INT_DIV > 1) ? $clog2(INT_DIV) : 1;
  localparam logic [SIL_W-1:0] SIL_MAX = SIL_W'(EXT_TIMEOUT);
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(INT_DIV - 1);

  logic extMeta, extSync, extPrev;
  logic extRise;
  logic [SIL_W-1:0] silentCnt;
  logic [DIV_W-1:0] divCnt;
  logic intTick;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      extMeta <= 1'b0;
      extSync <= 1'b0;
      extPrev <= 1'b0;
    end else begin
      extMeta <= extClk;
      extSync <= extMeta;
      extPrev <= extSync;
    end
  end

  assign extRise = extSync & ~extPrev;

  // Counts system clocks since the last external edge, saturating at the timeout.
  always_ff @(posedge clk) begin
    if (!rstN)                  silentCnt <= SIL_MAX;
    else if (extRise)           silentCnt <= '0;
    else if (silentCnt != SIL_MAX) silentCnt <= silentCnt + 1'b1;
  end

  assign extActive = (silentCnt != SIL_MAX);

  // Internal divider, held at zero while the external clock is alive.
  always_ff @(posedge clk) begin
    if (!rstN || extActive)     divCnt <= '0;
    else if (divCnt == DIV_LAST) divCnt <= '0;
    else                        divCnt <= divCnt + 1'b1;
  end

  assign intTick = !extActive && (divCnt == DIV_LAST);
  assign tick    = extActive ? extRise : intTick;

endmodule

// File: rtl/fg_datapath.sv
module fg_datapath
  import fault_guard_pkg::*;
#(
  parameter int CODE_W  = 4,
  parameter int OC_BASE = 33,
  parameter int OC_STEP = 66,
  parameter int SC_STEP = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  tick,
  input  logic [NUM_FAULTS-1:0] flags,
  input  logic [CODE_W-1:0]     chgOcCode,
  input  logic [CODE_W-1:0]     dsgOlCode,
  input  logic [CODE_W-1:0]     chgScCode,
  input  logic [CODE_W-1:0]     dsgScCode,
  input  ctrlStrobe_t           strobe,
  output logic [NUM_FAULTS-1:0] trip
);
  localparam int CODE_MAX = (1 << CODE_W) - 1;
  localparam int OC_MAX   = OC_BASE + OC_STEP * CODE_MAX;
  localparam int SC_MAX   = SC_STEP * CODE_MAX;
  localparam int LIM_MAX  = (OC_MAX > SC_MAX) ? OC_MAX : SC_MAX;
  localparam int CNT_W    = $clog2(LIM_MAX + 1);

  logic [CODE_W-1:0] codeArr [NUM_FAULTS];

  assign codeArr[FIDX_DSG_SC] = dsgScCode;
  assign codeArr[FIDX_CHG_SC] = chgScCode;
  assign codeArr[FIDX_DSG_OL] = dsgOlCode;
  assign codeArr[FIDX_CHG_OC] = chgOcCode;

  for (genvar i = 0; i < NUM_FAULTS; i++) begin : g_timer
    logic [CNT_W-1:0] limit;
    logic [CNT_W-1:0] count;
    logic             running;

    if (i == FIDX_DSG_OL || i == FIDX_CHG_OC) begin : g_oc
      assign limit = CNT_W'(OC_BASE) + CNT_W'(OC_STEP) * CNT_W'(codeArr[i]);
    end else begin : g_sc
      assign limit = CNT_W'(SC_STEP) * CNT_W'(codeArr[i]);
    end

    assign running = strobe.detectEn && flags[i];

    always_ff @(posedge clk) begin
      if (!rstN || !running || strobe.clearAll) count <= '0;
      else if (tick && (count < limit))        count <= count + 1'b1;
    end

    assign trip[i] = running && (count >= limit);
  end

endmodule

// File: rtl/fg_control.sv
module fg_control
  import fault_guard_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NUM_FAULTS-1:0] trip,
  input  logic                  hostChgEn,
  input  logic                  hostDsgEn,
  input  logic                  hostPchgOff,
  input  logic                  hostRelease,
  input  logic                  enPinN,
  input  logic                  shutdown,
  output ctrlStrobe_t           strobe,
  output logic                  chgDrive,
  output logic                  dsgDrive,
  output logic                  pchgDrive,
  output logic                  faultLatched,
  output logic [NUM_FAULTS-1:0] faultFlags
);
  logic relPrev;
  logic relArmed;
  logic relRise, relFall;
  logic releaseNow;
  logic gateOk;

  assign relRise    = hostRelease & ~relPrev;
  assign relFall    = ~hostRelease & relPrev;
  assign releaseNow = relFall & relArmed;
  assign faultLatched = |faultFlags;
  assign gateOk     = !enPinN && !shutdown;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      relPrev    <= 1'b1;
      relArmed   <= 1'b0;
      faultFlags <= '0;
    end else begin
      relPrev <= hostRelease;
      if (releaseNow) begin
        faultFlags <= '0;
        relArmed   <= 1'b0;
      end else begin
        faultFlags <= faultFlags | trip;
        if (relRise && faultLatched) relArmed <= 1'b1;
      end
    end
  end

  always_comb begin
    strobe.detectEn = gateOk && !faultLatched && (hostChgEn || hostDsgEn);
    strobe.clearAll = releaseNow;
  end

  assign chgDrive  = gateOk && !faultLatched && hostChgEn;
  assign dsgDrive  = gateOk && !faultLatched && hostDsgEn;
  assign pchgDrive = gateOk && (faultLatched || !hostPchgOff);

endmodule

// File: rtl/pack_fault_guard.sv
module pack_fault_guard
  import fault_guard_pkg::*;
#(
  parameter int INT_DIV     = 1526,
  parameter int EXT_TIMEOUT = 4096,
  parameter int CODE_W      = 4,
  parameter int OC_BASE     = 33,
  parameter int OC_STEP     = 66,
  parameter int SC_STEP     = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              extClk,
  input  logic              fltChgOc,
  input  logic              fltDsgOl,
  input  logic              fltChgSc,
  input  logic              fltDsgSc,
  input  logic [CODE_W-1:0] chgOcCode,
  input  logic [CODE_W-1:0] dsgOlCode,
  input  logic [CODE_W-1:0] chgScCode,
  input  logic [CODE_W-1:0] dsgScCode,
  input  logic              hostChgEn,
  input  logic              hostDsgEn,
  input  logic              hostPchgOff,
  input  logic              hostRelease,
  input  logic              enPinN,
  input  logic              shutdown,
  output logic              chgDrive,
  output logic              dsgDrive,
  output logic              pchgDrive,
  output logic              faultLatched,
  output logic [3:0]        faultFlags,
  output logic              timebaseExt
);
  logic                  tick;
  logic [NUM_FAULTS-1:0] flags;
  logic [NUM_FAULTS-1:0] trip;
  ctrlStrobe_t           strobe;

  assign flags = {fltChgOc, fltDsgOl, fltChgSc, fltDsgSc};

  fg_timebase #(.INT_DIV(INT_DIV), .EXT_TIMEOUT(EXT_TIMEOUT)) u_timebase (
    .clk(clk), .rstN(rstN), .extClk(extClk), .tick(tick), .extActive(timebaseExt)
  );

  fg_datapath #(.CODE_W(CODE_W), .OC_BASE(OC_BASE), .OC_STEP(OC_STEP), .SC_STEP(SC_STEP)) u_datapath (
    .clk(clk), .rstN(rstN), .tick(tick), .flags(flags),
    .chgOcCode(chgOcCode), .dsgOlCode(dsgOlCode), .chgScCode(chgScCode), .dsgScCode(dsgScCode),
    .strobe(strobe), .trip(trip)
  );

  fg_control u_control (
    .clk(clk), .rstN(rstN), .trip(trip),
    .hostChgEn(hostChgEn), .hostDsgEn(hostDsgEn), .hostPchgOff(hostPchgOff),
    .hostRelease(hostRelease), .enPinN(enPinN), .shutdown(shutdown),
    .strobe(strobe), .chgDrive(chgDrive), .dsgDrive(dsgDrive), .pchgDrive(pchgDrive),
    .faultLatched(faultLatched), .faultFlags(faultFlags)
  );

endmodule

// File: rtl/fg_checker.sv
module fg_checker (
  input logic       clk,
  input logic       rstN,
  input logic [3:0] flags,
  input logic       hostChgEn,
  input logic       hostDsgEn,
  input logic       hostRelease,
  input logic       enPinN,
  input logic       shutdown,
  input logic       chgDrive,
  input logic       dsgDrive,
  input logic       pchgDrive,
  input logic       faultLatched
);
  // R4
  latched_drives_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    faultLatched |-> (!chgDrive && !dsgDrive));

  // R4
  latch_has_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(faultLatched) |-> $past(|flags));

  // R5
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (faultLatched && hostRelease) |=> faultLatched);

  // R6
  chg_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    chgDrive |-> (hostChgEn && !enPinN && !shutdown));

  // R7
  pchg_on_latched_chk: assert property (@(posedge clk) disable iff (!rstN)
    (faultLatched && !enPinN && !shutdown) |-> pchgDrive);

  // R8
  forced_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    (enPinN || shutdown) |-> (!chgDrive && !dsgDrive && !pchgDrive));

  // R9
  mask_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!hostChgEn && !hostDsgEn) |=> !$rose(faultLatched));
endmodule

bind pack_fault_guard fg_checker u_fg_checker (
  .clk(clk), .rstN(rstN),
  .flags({fltChgOc, fltDsgOl, fltChgSc, fltDsgSc}),
  .hostChgEn(hostChgEn), .hostDsgEn(hostDsgEn), .hostRelease(hostRelease),
  .enPinN(enPinN), .shutdown(shutdown),
  .chgDrive(chgDrive), .dsgDrive(dsgDrive), .pchgDrive(pchgDrive),
  .faultLatched(faultLatched)
);

// File: tb/test_pack_fault_guard.sv
`timescale 1ns/1ps
module test_pack_fault_guard;
  localparam int DIV = 4;
  localparam int TMO = 40;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic extClk = 1'b0;
  logic fltChgOc = 0, fltDsgOl = 0, fltChgSc = 0, fltDsgSc = 0;
  logic [3:0] chgOcCode = 0, dsgOlCode = 0, chgScCode = 0, dsgScCode = 0;
  logic hostChgEn = 0, hostDsgEn = 0, hostPchgOff = 0, hostRelease = 0;
  logic enPinN = 1, shutdown = 0;
  logic chgDrive, dsgDrive, pchgDrive, faultLatched, timebaseExt;
  logic [3:0] faultFlags;

  int checks = 0;
  int fails = 0;
  bit extRun = 0;

  always #10 clk = ~clk;

  pack_fault_guard #(.INT_DIV(DIV), .EXT_TIMEOUT(TMO)) i_pack_fault_guard (
    .clk(clk), .rstN(rstN), .extClk(extClk),
    .fltChgOc(fltChgOc), .fltDsgOl(fltDsgOl), .fltChgSc(fltChgSc), .fltDsgSc(fltDsgSc),
    .chgOcCode(chgOcCode), .dsgOlCode(dsgOlCode), .chgScCode(chgScCode), .dsgScCode(dsgScCode),
    .hostChgEn(hostChgEn), .hostDsgEn(hostDsgEn), .hostPchgOff(hostPchgOff),
    .hostRelease(hostRelease), .enPinN(enPinN), .shutdown(shutdown),
    .chgDrive(chgDrive), .dsgDrive(dsgDrive), .pchgDrive(pchgDrive),
    .faultLatched(faultLatched), .faultFlags(faultFlags), .timebaseExt(timebaseExt)
  );

  // External slow clock: toggles every 5 system clocks while enabled (10-clock period).
  initial forever begin
    repeat (5) @(negedge clk);
    if (extRun) extClk = ~extClk;
  end

  initial begin
    #3000000;
    fails++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  function automatic logic [2:0] expDrives(logic c, logic d, logic p, logic pin, logic sd, logic lat);
    logic ok;
    ok = !pin && !sd;
    return {ok && !lat && c, ok && !lat && d, ok && (lat || !p)};
  endfunction

  function automatic int tripTicks(int idx, int code);
    if (idx >= 2) return 33 + 66 * code;
    return 2 * code;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic waitClk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setFlag(int idx, logic v);
    case (idx)
      0: fltDsgSc = v;
      1: fltChgSc = v;
      2: fltDsgOl = v;
      default: fltChgOc = v;
    endcase
  endtask

  task automatic setCode(int idx, int code);
    case (idx)
      0: dsgScCode = 4'(code);
      1: chgScCode = 4'(code);
      2: dsgOlCode = 4'(code);
      default: chgOcCode = 4'(code);
    endcase
  endtask

  task automatic doRelease();
    hostRelease = 1; waitClk(2);
    hostRelease = 0; waitClk(2);
  endtask

  // Raise a flag and count clocks until the latch sets.
  task automatic measure(int idx, int code, output int cycles);
    setCode(idx, code);
    setFlag(idx, 1);
    cycles = 0;
    while (!faultLatched && cycles < 6000) begin
      waitClk(1);
      cycles++;
    end
    setFlag(idx, 0);
  endtask

  initial begin
    int cyc;
    int unsigned seedInit;
    seedInit = $urandom(1357);
    waitClk(3);
    rstN = 1;
    waitClk(1);
    // R8 reset state: pin high by default forces all drives off
    check({chgDrive, dsgDrive, pchgDrive} == 3'b000, "R8", {chgDrive, dsgDrive, pchgDrive}, 0);
    check(faultFlags == 4'h0, "R4", faultFlags, 0);
    enPinN = 0;
    waitClk(1);
    // R6 R7 defaults: charge/discharge off, precharge on
    check({chgDrive, dsgDrive, pchgDrive} == 3'b001, "R6", {chgDrive, dsgDrive, pchgDrive}, 1);

    // R6 R7 R8 random gating patterns without faults
    for (int k = 0; k < 24; k++) begin
      logic [4:0] r;
      logic [2:0] e;
      r = 5'($urandom);
      hostChgEn = r[0]; hostDsgEn = r[1]; hostPchgOff = r[2];
      enPinN = r[3] & r[4]; shutdown = r[4] & ~r[3];
      waitClk(1);
      e = expDrives(hostChgEn, hostDsgEn, hostPchgOff, enPinN, shutdown, 0);
      check({chgDrive, dsgDrive, pchgDrive} == e, "R6/R7/R8 gating", {chgDrive, dsgDrive, pchgDrive}, e);
    end
    enPinN = 0; shutdown = 0; hostChgEn = 1; hostDsgEn = 1; hostPchgOff = 1;
    waitClk(2);

    // R2 code 0 trips at the first edge; R4 outputs and flag position
    dsgScCode = 0;
    fltDsgSc = 1;
    waitClk(1);
    check(faultLatched == 1, "R2", faultLatched, 1);
    check(faultFlags == 4'b0001, "R4", faultFlags, 1);
    check({chgDrive, dsgDrive, pchgDrive} == 3'b001, "R4", {chgDrive, dsgDrive, pchgDrive}, 1);
    fltDsgSc = 0;

    // R5 release held high keeps the latch
    hostRelease = 1;
    waitClk(10);
    check(faultLatched == 1, "R5 held", faultLatched, 1);
    hostRelease = 0;
    waitClk(2);
    check(faultLatched == 0, "R5 released", faultLatched, 0);
    check({chgDrive, dsgDrive, pchgDrive} == 3'b110, "R6", {chgDrive, dsgDrive, pchgDrive}, 6);

    // R5 persistent fault latches again after release
    chgScCode = 0;
    fltChgSc = 1;
    waitClk(2);
    doRelease();
    waitClk(2);
    check(faultLatched == 1 && faultFlags == 4'b0010, "R5 retrip", faultFlags, 2);
    fltChgSc = 0;
    doRelease();

    // R1 R2 blanking times, directed long OC then random directions/codes
    measure(3, 15, cyc);
    check(cyc >= 1022 * DIV && cyc <= 1023 * DIV + 3, "R1 code15", cyc, 1023 * DIV);
    check(faultFlags == 4'b1000, "R4 chgOc bit", faultFlags, 8);
    doRelease();
    for (int k = 0; k < 8; k++) begin
      int idx, code, lim, lo;
      idx = int'($urandom_range(3, 0));
      code = (idx >= 2) ? int'($urandom_range(3, 0)) : int'($urandom_range(15, 0));
      lim = tripTicks(idx, code);
      lo = (lim > 0) ? (lim - 1) * DIV : 0;
      measure(idx, code, cyc);
      check(cyc >= lo && cyc <= lim * DIV + 3, (idx >= 2) ? "R1 random" : "R2 random", cyc, lim * DIV);
      check(faultFlags == 4'(1 << idx), "R4 random", faultFlags, 1 << idx);
      doRelease();
    end

    // R3 short pulses below the limit latch nothing and do not accumulate
    chgOcCode = 0;
    fltChgOc = 1; waitClk(100); fltChgOc = 0; waitClk(5);
    check(faultLatched == 0, "R3 pulse1", faultLatched, 0);
    fltChgOc = 1; waitClk(100); fltChgOc = 0; waitClk(5);
    check(faultLatched == 0, "R3 pulse2", faultLatched, 0);

    // R9 masked while only precharge is active
    hostChgEn = 0; hostDsgEn = 0; hostPchgOff = 0;
    dsgScCode = 0; fltDsgSc = 1;
    waitClk(20);
    check(faultLatched == 0, "R9 masked", faultLatched, 0);
    check(pchgDrive == 1, "R9 pchg", pchgDrive, 1);
    fltDsgSc = 0;
    hostChgEn = 1; hostDsgEn = 1;
    waitClk(2);

    // R10 external timebase and failover
    check(timebaseExt == 0, "R10 idle", timebaseExt, 0);
    extRun = 1;
    waitClk(30);
    check(timebaseExt == 1, "R10 ext active", timebaseExt, 1);
    measure(0, 3, cyc);
    check(cyc >= 45 && cyc <= 75, "R10 ext timing", cyc, 60);
    doRelease();
    extRun = 0;
    waitClk(TMO + 20);
    check(timebaseExt == 0, "R10 failover", timebaseExt, 0);
    measure(0, 3, cyc);
    check(cyc >= 5 * DIV && cyc <= 6 * DIV + 3, "R10 internal timing", cyc, 6 * DIV);
    doRelease();

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule